// File: doc/BRIEF.md
# Binary/Decimal Arithmetic Unit with Digit Correction

This block is the arithmetic core of a small 8-bit processor datapath. A purely combinational unit takes two operands, a carry input, an overflow input, a bypass input and a six-bit function code. It returns a result, the negative, zero, carry and overflow flags, a separate program-counter carry, and two per-digit decimal overflow flags. The program-counter carry is the carry of a plain `op1 + op2`, which is the low-byte step of a relative branch. Its sense is inverted when function bit 0 marks the branch offset as negative.

Decimal arithmetic takes two passes. The first pass is an ordinary binary add or subtract. During that pass the unit reports which decimal digits overflowed (on add) or borrowed (on subtract). A small registered generator turns those flags into a correction constant, with 6 in each flagged digit position (0x06, 0x60 or 0x66). The surrounding sequencer then adds or subtracts that constant from the binary result in a second pass. The generator is cleared on every opcode fetch and frozen while the datapath is stalled. Scheduling the second pass is left to the caller.

Top module: `bcd_alu_top`

## Requirements
- R1: Operation is selected by `func[5:1]`. Code 1 gives `op1+op2+cin`, with `flag_c` the carry out. Code 2 gives `op1-op2-(1-cin)`, with `flag_c`=1 meaning no borrow. On both, `flag_v` is two's-complement overflow.
- R2: Codes 3, 4 and 5 give AND, OR and XOR. On these codes `flag_c` equals `cin` and `flag_v` equals `vin`.
- R3: Code 6 gives `op1+1` modulo 256 and code 7 gives `op1-1` modulo 256. On both, `flag_c`=`cin` and `flag_v`=`vin`.
- R4: Code 8 shifts left and fills with 0. Code 9 shifts right and fills with 0. Code 10 rotates left with `cin` entering bit 0. Code 11 rotates right with `cin` entering bit 7. On all four, `flag_c` is the bit shifted out and `flag_v`=`vin`.
- R5: For every code, `flag_n` is bit 7 of `result` and `flag_z` is 1 exactly when `result` is zero.
- R6: Code 0 and the unused codes 12 to 31 pass `op1` to `result` with `flag_c`=`cin` and `flag_v`=`vin`. A high `bypass` forces this same pass behaviour whatever the code.
- R7: `pc_carry` is the carry out of `op1+op2` (no carry-in), XORed with `func[0]`.
- R8: On code 1, `bcd_ovf_lo` is set when `op1[3:0]+op2[3:0]+cin` exceeds 9. `bcd_ovf_hi` is set when `op1[7:4]+op2[7:4]+bcd_ovf_lo` exceeds 9. For decimal operands, `result` plus 0x06 (if lo) plus 0x60 (if hi), modulo 256, is then the decimal sum, and `bcd_ovf_hi` is the decimal carry.
- R9: On code 2, `bcd_ovf_lo` is set when `op1[3:0]-op2[3:0]-(1-cin)` is negative. `bcd_ovf_hi` is set when `op1[7:4]-op2[7:4]-bcd_ovf_lo` is negative. `result` minus the constant is then the decimal difference. On every other code, and under `bypass`, both flags are 0.
- R10: While `dec_en` is high, a rising clock edge loads 6 into the low digit of `fix_const` when `bcd_ovf_lo` is set, and into the high digit when `bcd_ovf_hi` is set. Unflagged digits keep their value. With `dec_en` low, no digit changes.
- R11: Synchronous `rst` clears `fix_const`. Otherwise a high `hold` freezes it. Otherwise a high `fetch_clr` clears it. Clearing takes priority over loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Stall; freezes the correction register |
| fetch_clr | input | 1 | Opcode fetch; clears the correction register |
| dec_en | input | 1 | Decimal mode enable |
| bypass | input | 1 | Force pass of op1 |
| cin | input | 1 | Carry in |
| vin | input | 1 | Overflow in |
| op1 | input | 8 | First operand |
| op2 | input | 8 | Second operand |
| func | input | 6 | [5:1] operation, [0] negative branch offset |
| result | output | 8 | Result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| pc_carry | output | 1 | Program-counter carry |
| bcd_ovf_lo | output | 1 | Low-digit decimal overflow/borrow |
| bcd_ovf_hi | output | 1 | High-digit decimal overflow/borrow |
| fix_const | output | 8 | Registered correction constant |

## Verification
The assertions assume that the control inputs `hold`, `fetch_clr` and `dec_en` are at defined levels at each clock edge. They also assume that the digit flags only ever ask for the value 6. The correction constant is checked against "only 0 or 6 per digit" under that premise. The decimal property is meaningful only when both operands hold valid decimal digits, so the decimal sweep covers exactly the 100×100 valid operand pairs with both carry values. The binary sweeps cover arbitrary bytes. The register sequence toggles `hold` and `fetch_clr` only between edges, with the ALU inputs held steady across each edge.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [4:0] {
    OP_PASS = 5'd0,
    OP_ADC  = 5'd1,
    OP_SBC  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_ASL  = 5'd8,
    OP_LSR  = 5'd9,
    OP_ROL  = 5'd10,
    OP_ROR  = 5'd11
  } alu_op_e;

  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;
  localparam int DIGIT_FIX = 6;
endpackage

// File: rtl/bcd_alu_core.sv
module bcd_alu_core
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic               bypass,
  input  logic               cin,
  input  logic               vin,
  input  logic [DW-1:0]      op1,
  input  logic [DW-1:0]      op2,
  input  logic [5:0]         func,
  output logic [DW-1:0]      result,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_v,
  output logic               pc_carry,
  output logic [DW/DIGIT_W-1:0] dig_ovf
);
  localparam int NDIG = DW / DIGIT_W;

  alu_op_e op;
  logic [DW:0]   sum_w, dif_w;
  logic [DW-1:0] pc_lo;
  logic          is_add, is_sub;

  assign op     = bypass ? OP_PASS : alu_op_e'(func[5:1]);
  assign is_add = (op == OP_ADC);
  assign is_sub = (op == OP_SBC);

  assign sum_w = {1'b0, op1} + {1'b0, op2} + {{DW{1'b0}}, cin};
  assign dif_w = {1'b0, op1} + {1'b0, ~op2} + {{DW{1'b0}}, cin};

  // branch-offset carry on the low byte
  assign pc_lo    = op1 + op2;
  assign pc_carry = (pc_lo < op1) ^ func[0];

  always_comb begin
    result = op1;
    flag_c = cin;
    flag_v = vin;
    unique case (op)
      OP_ADC: begin
        result = sum_w[DW-1:0];
        flag_c = sum_w[DW];
        flag_v = (op1[DW-1] == op2[DW-1]) && (sum_w[DW-1] != op1[DW-1]);
      end
      OP_SBC: begin
        result = dif_w[DW-1:0];
        flag_c = dif_w[DW];
        flag_v = (op1[DW-1] != op2[DW-1]) && (dif_w[DW-1] != op1[DW-1]);
      end
      OP_AND: result = op1 & op2;
      OP_OR:  result = op1 | op2;
      OP_XOR: result = op1 ^ op2;
      OP_INC: result = op1 + 1'b1;
      OP_DEC: result = op1 - 1'b1;
      OP_ASL: begin result = {op1[DW-2:0], 1'b0}; flag_c = op1[DW-1]; end
      OP_LSR: begin result = {1'b0, op1[DW-1:1]}; flag_c = op1[0];    end
      OP_ROL: begin result = {op1[DW-2:0], cin};  flag_c = op1[DW-1]; end
      OP_ROR: begin result = {cin, op1[DW-1:1]};  flag_c = op1[0];    end
      default: ;
    endcase
  end

  assign flag_n = result[DW-1];
  assign flag_z = (result == '0);

  // per-digit decimal carry/borrow chain
  logic [NDIG:0] dchain;
  assign dchain[0] = is_sub ? ~cin : cin;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [DIGIT_W:0] a_d, b_d, c_d, dval;
    logic             over;
    assign a_d  = {1'b0, op1[g*DIGIT_W +: DIGIT_W]};
    assign b_d  = {1'b0, op2[g*DIGIT_W +: DIGIT_W]};
    assign c_d  = {{DIGIT_W{1'b0}}, dchain[g]};
    assign dval = is_sub ? (a_d - b_d - c_d) : (a_d + b_d + c_d);
    assign over = is_sub ? dval[DIGIT_W] : (dval > (DIGIT_W+1)'(DIGIT_MAX));
    assign dchain[g+1] = over;
    assign dig_ovf[g]  = (is_add || is_sub) && over;
  end
endmodule

// File: rtl/bcd_fix_reg.sv
module bcd_fix_reg
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic                  fetch_clr,
  input  logic                  dec_en,
  input  logic [DW/DIGIT_W-1:0] dig_ovf,
  output logic [DW-1:0]         fix_const
);
  localparam int NDIG = DW / DIGIT_W;

  for (genvar g = 0; g < NDIG; g++) begin : g_nib
    logic [DIGIT_W-1:0] nib_q;
    always_ff @(posedge clk) begin
      if (rst)                    nib_q <= '0;
      else if (!hold) begin
        if (fetch_clr)            nib_q <= '0;
        else if (dec_en && dig_ovf[g]) nib_q <= DIGIT_W'(DIGIT_FIX);
      end
    end
    assign fix_const[g*DIGIT_W +: DIGIT_W] = nib_q;

    // R10
    nib_legal_chk: assert property (@(posedge clk) disable iff (rst)
      (nib_q == '0) || (nib_q == DIGIT_W'(DIGIT_FIX)));
  end

  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(fix_const));
  // R11
  fetch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_clr && !hold) |=> (fix_const == '0));
  // R10
  no_dec_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec_en && !fetch_clr) |=> $stable(fix_const));
endmodule

// File: rtl/bcd_alu_top.sv
module bcd_alu_top
  import bcd_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          fetch_clr,
  input  logic          dec_en,
  input  logic          bypass,
  input  logic          cin,
  input  logic          vin,
  input  logic [DW-1:0] op1,
  input  logic [DW-1:0] op2,
  input  logic [5:0]    func,
  output logic [DW-1:0] result,
  output logic          flag_n,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_v,
  output logic          pc_carry,
  output logic          bcd_ovf_lo,
  output logic          bcd_ovf_hi,
  output logic [DW-1:0] fix_const
);
  localparam int NDIG = DW / DIGIT_W;

  logic [NDIG-1:0] dig_ovf;

  bcd_alu_core #(.DW(DW)) i_core (
    .bypass(bypass), .cin(cin), .vin(vin), .op1(op1), .op2(op2), .func(func),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .pc_carry(pc_carry), .dig_ovf(dig_ovf)
  );

  bcd_fix_reg #(.DW(DW)) i_fix (
    .clk(clk), .rst(rst), .hold(hold), .fetch_clr(fetch_clr),
    .dec_en(dec_en), .dig_ovf(dig_ovf), .fix_const(fix_const)
  );

  assign bcd_ovf_lo = dig_ovf[0];
  assign bcd_ovf_hi = dig_ovf[NDIG-1];

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (result == op1 && flag_c == cin && flag_v == vin));
  // R9
  bcd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bypass || (func[5:1] != OP_ADC && func[5:1] != OP_SBC)) |-> (dig_ovf == '0));
  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    flag_z |-> (result == '0 && !flag_n));
endmodule

// File: tb/test_bcd_alu_top.sv
`timescale 1ns/1ps
module test_bcd_alu_top;
  logic clk = 1'b0, rst = 1'b1, hold = 1'b0, fetch_clr = 1'b0, dec_en = 1'b0;
  logic bypass = 1'b0, cin = 1'b0, vin = 1'b0;
  logic [7:0] op1 = '0, op2 = '0;
  logic [5:0] func = '0;
  logic [7:0] result, fix_const;
  logic flag_n, flag_z, flag_c, flag_v, pc_carry, bcd_ovf_lo, bcd_ovf_hi;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_alu_top i_bcd_alu_top (
    .clk(clk), .rst(rst), .hold(hold), .fetch_clr(fetch_clr), .dec_en(dec_en),
    .bypass(bypass), .cin(cin), .vin(vin), .op1(op1), .op2(op2), .func(func),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .pc_carry(pc_carry), .bcd_ovf_lo(bcd_ovf_lo),
    .bcd_ovf_hi(bcd_ovf_hi), .fix_const(fix_const)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic int to_bcd(input int x);
    return (x / 10) * 16 + (x % 10);
  endfunction

  // expected {result, n, z, c, v, pcc} packed as an int
  function automatic int model(input int code, input int a, input int b,
                               input int ci, input int vi, input int neg);
    int r, c, v, t, s, pcc;
    r = a; c = ci; v = vi;
    case (code)
      1: begin t = a + b + ci; r = t % 256; c = (t > 255);
               s = sgn(a) + sgn(b) + ci; v = (s > 127 || s < -128); end
      2: begin t = a - b - (1 - ci); r = (t + 256) % 256; c = (t >= 0);
               s = sgn(a) - sgn(b) - (1 - ci); v = (s > 127 || s < -128); end
      3: r = a & b;
      4: r = a | b;
      5: r = a ^ b;
      6: r = (a + 1) % 256;
      7: r = (a + 255) % 256;
      8: begin r = (a * 2) % 256; c = a / 128; end
      9: begin r = a / 2; c = a % 2; end
      10: begin r = (a * 2 + ci) % 256; c = a / 128; end
      11: begin r = a / 2 + ci * 128; c = a % 2; end
      default: ;
    endcase
    pcc = ((a + b) > 255) ? 1 : 0;
    pcc = pcc ^ neg;
    return (r << 5) | ((r >= 128) << 4) | ((r == 0) << 3) | (c << 2) | (v << 1) | pcc;
  endfunction

  function automatic string req_of(input int code);
    case (code)
      1, 2: return "R1";
      3, 4, 5: return "R2";
      6, 7: return "R3";
      8, 9, 10, 11: return "R4";
      default: return "R6";
    endcase
  endfunction

  function automatic int got();
    return (int'(result) << 5) | (int'(flag_n) << 4) | (int'(flag_z) << 3) |
           (int'(flag_c) << 2) | (int'(flag_v) << 1) | int'(pc_carry);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int neg, dl, dh, e, k;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 reset", fix_const, 0);
    @(negedge clk);
    rst = 1'b0; fetch_clr = 1'b1;   // keep register at zero during sweeps
    #0.05;

    // binary sweep, R1..R7
    for (int code = 0; code < 12; code++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b += 7) begin
            neg = ((a + b) % 3 == 0);
            op1 = 8'(a); op2 = 8'(b); cin = ci[0]; vin = a[1];
            func = {5'(code), neg[0]};
            #0.1;
            // R5 R7 folded into each comparison
            check(req_of(code), got(), model(code, a, b, ci, a[1], neg));
            if (code != 1 && code != 2) begin
              // R9 other codes keep digit flags low
              check("R9 quiet", {bcd_ovf_hi, bcd_ovf_lo}, 0);
            end
          end
        end
      end
    end

    // R6 unused codes and bypass
    for (int code = 12; code < 32; code++) begin
      for (int a = 0; a < 256; a += 13) begin
        op1 = 8'(a); op2 = 8'(255 - a); cin = a[0]; vin = a[2]; func = {5'(code), 1'b0};
        #0.1;
        check("R6 unused", got(), model(0, a, 255 - a, a[0], a[2], 0));
      end
    end
    bypass = 1'b1;
    for (int code = 0; code < 12; code++) begin
      op1 = 8'h99; op2 = 8'h99; cin = 1'b1; vin = 1'b0; func = {5'(code), 1'b1};
      #0.1;
      check("R6 bypass", got(), model(0, 8'h99, 8'h99, 1, 0, 1));
      check("R9 bypass", {bcd_ovf_hi, bcd_ovf_lo}, 0);
    end
    bypass = 1'b0;

    // decimal sweep R8 R9
    for (int sub = 0; sub < 2; sub++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int x = 0; x < 100; x++) begin
          for (int y = 0; y < 100; y++) begin
            op1 = 8'(to_bcd(x)); op2 = 8'(to_bcd(y)); cin = ci[0]; vin = 1'b0;
            func = {(sub != 0) ? 5'd2 : 5'd1, 1'b0};
            #0.1;
            if (sub == 0) begin
              dl = ((x % 10) + (y % 10) + ci > 9);
              e  = x + y + ci;
              dh = (e >= 100);
              k  = (int'(result) + dl * 6 + dh * 96) % 256;
              check("R8 flags", {bcd_ovf_hi, bcd_ovf_lo}, dh * 2 + dl);
              check("R8 corrected", k, to_bcd(e % 100));
            end else begin
              dl = ((x % 10) - (y % 10) - (1 - ci) < 0);
              e  = x - y - (1 - ci);
              dh = (e < 0);
              k  = (int'(result) - dl * 6 - dh * 96 + 512) % 256;
              check("R9 flags", {bcd_ovf_hi, bcd_ovf_lo}, dh * 2 + dl);
              check("R9 corrected", k, to_bcd((e + 100) % 100));
            end
          end
        end
      end
    end

    // correction register sequence
    @(negedge clk);
    fetch_clr = 1'b0; dec_en = 1'b1; cin = 1'b0;
    op1 = 8'h09; op2 = 8'h01; func = {5'd1, 1'b0};
    @(posedge clk); #1;
    check("R10 lo load", fix_const, 8'h06);
    @(negedge clk);
    op1 = 8'h90; op2 = 8'h10;
    @(posedge clk); #1;
    check("R10 hi load keeps lo", fix_const, 8'h66);
    @(negedge clk);
    hold = 1'b1; fetch_clr = 1'b1;
    @(posedge clk); #1;
    check("R11 hold freezes", fix_const, 8'h66);
    @(negedge clk);
    hold = 1'b0;
    @(posedge clk); #1;
    check("R11 fetch clears", fix_const, 8'h00);
    @(negedge clk);
    fetch_clr = 1'b0; dec_en = 1'b0; op1 = 8'h99; op2 = 8'h01;
    @(posedge clk); #1;
    check("R10 disabled", fix_const, 8'h00);
    @(negedge clk);
    dec_en = 1'b1; fetch_clr = 1'b1;   // fetch beats load
    @(posedge clk); #1;
    check("R11 fetch priority", fix_const, 8'h00);
    @(negedge clk);
    fetch_clr = 1'b0;
    @(posedge clk); #1;
    check("R10 both digits", fix_const, 8'h66);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11 reset clears", fix_const, 8'h00);
    @(negedge clk);
    rst = 1'b0; dec_en = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule